// File: doc/BRIEF.md
# TDM Serial Channel Port

This block connects a synchronous time-division-multiplexed serial line to parallel per-channel storage. A frame has 32 channels of 8 bits each. One bit cell lasts two periods of a bit clock that runs at twice the bit rate. Data leaves on the falling bit-clock edge that opens a cell and is captured on the rising edge three quarters of the way through it. An active-low frame pulse marks where channel 0 begins. On the receive side, each frame is broken into 32 channel bytes. Each byte goes into a receive store and is announced with a one-cycle strobe. On the transmit side, 32 bytes are taken from a transmit store and shifted out with the most significant bit first.

The block runs from a fast system clock. The bit clock and the frame pulse can come from outside the block (slave mode), in which case they are synchronized and edge-detected. In master mode the block generates them from the system clock and enables its timing pin drivers. If a frame pulse arrives at the wrong point in the frame, the block realigns to it and raises a sticky flag.

The serial line cannot be paused, so neither data port has back-pressure. The receive strobe is a valid-only stream that the consumer must accept in the cycle it appears. Writes to the transmit store are always accepted, so there is no ready signal.

Top module: `tdm_stream_port`

## Requirements
- R1: After reset and until the first frame pulse has been seen, `txd` is 1, `rx_valid` never pulses, and `slip` is 0.
- R2: The frame pulse is active low and sampled at bit-clock rising edges. A high-to-low change seen at a rising edge makes the next falling edge start channel 0, bit 7.
- R3: A bit cell spans two bit-clock periods. `txd` changes only at the falling edge that opens a cell. `rxd` is sampled at the second rising edge of the cell.
- R4: Within a channel, bits travel most significant first: bit 7, then down to bit 0.
- R5: Once bit 0 of channel c is captured, `rx_valid` pulses for one system clock cycle with `rx_chan`=c and `rx_data` set to the byte. There is no back-pressure.
- R6: `rd_data` returns the last byte received for channel `rd_chan` (combinational read).
- R7: A write with `tx_wr_valid` stores `tx_wr_data` for channel `tx_wr_chan`. Channel c+1's byte is fetched when bit 0 of channel c is launched. Channel 0's byte is fetched when the frame pulse is seen.
- R8: Channels run 0 to 31 and then wrap to 0, so a frame that is not re-marked continues in the same order.
- R9: A frame pulse seen while aligned, at any point other than the last rising edge of channel 31 bit 0, sets `slip` and realigns the counters. A pulse at that expected edge leaves `slip` unchanged.
- R10: `slip` stays set until `slip_clr` is high for a cycle. A new slip in the same cycle takes priority over the clear.
- R11: When `master`=1, `bclk_oe` and `fp_oe` are 1. `bclk_o` has a period of 2*BCLK_HALF system clocks. `fp_n_o` goes low at a `bclk_o` falling edge, stays low for one bit-clock period, and repeats every 512 bit-clock periods. When `master`=0, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: generate bit clock and frame pulse; 0: take them from pins |
| bclk_i | input | 1 | Bit clock from outside (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| bclk_oe | output | 1 | Drive enable for the bit-clock pin |
| fp_n_i | input | 1 | Active-low frame pulse from outside |
| fp_n_o | output | 1 | Generated active-low frame pulse |
| fp_oe | output | 1 | Drive enable for the frame-pulse pin |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data, idle 1 |
| tx_wr_valid | input | 1 | Write strobe for the transmit store |
| tx_wr_chan | input | 5 | Channel being written |
| tx_wr_data | input | 8 | Byte being written |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_chan | output | 5 | Channel of the received byte |
| rx_data | output | 8 | Received byte |
| rd_chan | input | 5 | Receive store read address |
| rd_data | output | 8 | Receive store read data |
| slip | output | 1 | Sticky misplaced-frame-pulse flag |
| slip_clr | input | 1 | Clears `slip` |

## Verification
The first corner case is the stretch before any frame pulse arrives. A design that sends data or strobes before it has aligned would show non-idle `txd` bytes or unexpected receive strobes that the scoreboard rejects. The bench also places a frame pulse inside channel 9 and checks three things. The flag must rise, the partial frame's received bytes must still be delivered, and the next frame must start again at channel 0. A design that ignored the pulse would shift every later byte by the wrong channel count. Reversed bit order, capture on the wrong edge, or a late fetch from the transmit store would each corrupt the bytes rebuilt from `txd`. In master mode, the bench times the generated clock period, the width of the frame pulse, and the frame spacing.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [2:0]        bitidx_t;
endpackage

// File: rtl/tdm_clkgen.sv
module tdm_clkgen #(
  parameter int CH        = 32,
  parameter int BCLK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk_o,
  output logic fp_n_o
);
  localparam int PERIODS = CH * tdm_pkg::BYTE_W * 2;
  localparam int PW      = $clog2(PERIODS);
  localparam int DW      = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;

  logic [DW-1:0] div_q;
  logic [PW-1:0] per_q;
  logic [PW-1:0] per_nx;

  always_comb per_nx = (per_q == PW'(PERIODS - 1)) ? '0 : per_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; per_q <= '0; bclk_o <= 1'b1; fp_n_o <= 1'b1;
    end else if (!en) begin
      div_q <= '0; per_q <= '0; bclk_o <= 1'b1; fp_n_o <= 1'b1;
    end else if (div_q == DW'(BCLK_HALF - 1)) begin
      div_q  <= '0;
      bclk_o <= ~bclk_o;
      if (bclk_o) begin
        per_q  <= per_nx;
        fp_n_o <= (per_nx != PW'(PERIODS - 1));
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R11: the generated frame pulse only moves together with a bit-clock fall
  p_fp_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(fp_n_o)) |-> $fell(bclk_o));
endmodule

// File: rtl/tdm_timing.sv
module tdm_timing #(
  parameter int CH   = 32,
  parameter int SYNC = 2,
  localparam int CW  = $clog2(CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_src,
  input  logic            fp_src,
  input  logic            rxd_src,
  input  logic            slip_clr,
  output logic            launch,
  output logic            sample,
  output logic            marker,
  output logic            sbit,
  output tdm_pkg::bitidx_t bitn,
  output logic [CW-1:0]   chan,
  output logic            locked,
  output logic            slip
);
  logic [SYNC-1:0][2:0] sq;
  logic bclk_s, fp_s, rxd_s, bclk_d, fp_d;
  logic rise, fall, half, pend, frame_end, slip_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '1;
    else        sq <= {sq[SYNC-2:0], {bclk_src, fp_src, rxd_src}};
  end

  assign {bclk_s, fp_s, rxd_s} = sq[SYNC-1];
  assign rise      = bclk_s & ~bclk_d;
  assign fall      = ~bclk_s & bclk_d;
  assign frame_end = half && (bitn == 3'd0) && (chan == CW'(CH - 1));
  assign slip_evt  = rise && !fp_s && fp_d && locked && !frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b1; fp_d <= 1'b1; half <= 1'b0; pend <= 1'b0;
      bitn <= 3'd7; chan <= '0; locked <= 1'b0;
      launch <= 1'b0; sample <= 1'b0; marker <= 1'b0; sbit <= 1'b1;
    end else begin
      bclk_d <= bclk_s;
      launch <= 1'b0; sample <= 1'b0; marker <= 1'b0;
      if (fall) begin
        if (pend) begin
          pend <= 1'b0; locked <= 1'b1; half <= 1'b0;
          bitn <= 3'd7; chan <= '0; launch <= 1'b1;
        end else if (half) begin
          half   <= 1'b0;
          bitn   <= bitn - 3'd1;
          launch <= locked;
          if (bitn == 3'd0) chan <= (chan == CW'(CH - 1)) ? '0 : chan + 1'b1;
        end else begin
          half <= 1'b1;
        end
      end
      if (rise) begin
        fp_d <= fp_s;
        if (half && locked) begin
          sample <= 1'b1;
          sbit   <= rxd_s;
        end
        if (!fp_s && fp_d) begin
          pend   <= 1'b1;
          marker <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slip <= 1'b0;
    else if (slip_evt) slip <= 1'b1;
    else if (slip_clr) slip <= 1'b0;
  end

  // R10: the flag holds until cleared
  p_slip_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slip && !slip_clr) |=> slip);
  // R3: launches and samples come from distinct bit-clock edges
  p_edges_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && sample));
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int CH  = 32,
  localparam int CW = $clog2(CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             sbit,
  input  logic             locked,
  input  tdm_pkg::bitidx_t bitn,
  input  logic [CW-1:0]    chan,
  input  logic [CW-1:0]    rd_chan,
  output tdm_pkg::byte_t   rd_data,
  output logic             rx_valid,
  output logic [CW-1:0]    rx_chan,
  output tdm_pkg::byte_t   rx_data
);
  tdm_pkg::byte_t sr, rbuf [CH], full;

  assign full    = {sr[6:0], sbit};
  assign rd_data = rbuf[rd_chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; rx_valid <= 1'b0; rx_chan <= '0; rx_data <= '0;
      for (int i = 0; i < CH; i++) rbuf[i] <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (sample) begin
        sr <= full;
        if (bitn == 3'd0) begin
          rbuf[chan] <= full;
          rx_valid   <= 1'b1;
          rx_chan    <= chan;
          rx_data    <= full;
        end
      end
    end
  end

  p_rx_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> locked);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int CH  = 32,
  localparam int CW = $clog2(CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             marker,
  input  logic             locked,
  input  tdm_pkg::bitidx_t bitn,
  input  logic [CW-1:0]    chan,
  input  logic             wr_valid,
  input  logic [CW-1:0]    wr_chan,
  input  tdm_pkg::byte_t   wr_data,
  output logic             txd
);
  tdm_pkg::byte_t tbuf [CH], cur, nxt;
  logic [CW-1:0] chan_nx;

  assign chan_nx = (chan == CW'(CH - 1)) ? '0 : chan + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) tbuf[i] <= '0;
    end else if (wr_valid) begin
      tbuf[wr_chan] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '1; nxt <= '1; txd <= 1'b1;
    end else begin
      if (marker) nxt <= tbuf[0];
      if (launch) begin
        if (bitn == 3'd7) begin
          cur <= nxt;
          txd <= nxt[7];
        end else begin
          txd <= cur[bitn];
        end
        if (bitn == 3'd0) nxt <= tbuf[chan_nx];
      end
    end
  end

  p_txd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> txd);
  p_txd_on_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(launch));
endmodule

// File: rtl/tdm_stream_port.sv
module tdm_stream_port #(
  parameter int CH        = 32,
  parameter int BCLK_HALF = 4,
  parameter int SYNC      = 2,
  localparam int CW       = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          bclk_i,
  output logic          bclk_o,
  output logic          bclk_oe,
  input  logic          fp_n_i,
  output logic          fp_n_o,
  output logic          fp_oe,
  input  logic          rxd,
  output logic          txd,
  input  logic          tx_wr_valid,
  input  logic [CW-1:0] tx_wr_chan,
  input  logic [7:0]    tx_wr_data,
  output logic          rx_valid,
  output logic [CW-1:0] rx_chan,
  output logic [7:0]    rx_data,
  input  logic [CW-1:0] rd_chan,
  output logic [7:0]    rd_data,
  output logic          slip,
  input  logic          slip_clr
);
  logic launch, sample, marker, sbit, locked;
  tdm_pkg::bitidx_t bitn;
  logic [CW-1:0] chan;

  assign bclk_oe = master;
  assign fp_oe   = master;

  tdm_clkgen #(.CH(CH), .BCLK_HALF(BCLK_HALF)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(master), .bclk_o(bclk_o), .fp_n_o(fp_n_o));

  tdm_timing #(.CH(CH), .SYNC(SYNC)) u_tim (
    .clk(clk), .rst_n(rst_n),
    .bclk_src(master ? bclk_o : bclk_i),
    .fp_src(master ? fp_n_o : fp_n_i),
    .rxd_src(rxd), .slip_clr(slip_clr),
    .launch(launch), .sample(sample), .marker(marker), .sbit(sbit),
    .bitn(bitn), .chan(chan), .locked(locked), .slip(slip));

  tdm_rx #(.CH(CH)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample), .sbit(sbit), .locked(locked),
    .bitn(bitn), .chan(chan), .rd_chan(rd_chan), .rd_data(rd_data),
    .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_data(rx_data));

  tdm_tx #(.CH(CH)) u_tx (
    .clk(clk), .rst_n(rst_n), .launch(launch), .marker(marker), .locked(locked),
    .bitn(bitn), .chan(chan), .wr_valid(tx_wr_valid), .wr_chan(tx_wr_chan),
    .wr_data(tx_wr_data), .txd(txd));
endmodule

// File: tb/tb_tdm_stream_port.sv
module tb_tdm_stream_port;
  localparam int CLK_PERIOD = 10;
  localparam int HQ = 4;

  logic clk = 0, rst_n = 0, master = 0, bclk_i = 1, fp_n_i = 1, rxd = 1;
  logic tx_wr_valid = 0, slip_clr = 0;
  logic [4:0] tx_wr_chan = 0, rd_chan = 0, rx_chan;
  logic [7:0] tx_wr_data = 0, rx_data, rd_data;
  logic bclk_o, bclk_oe, fp_n_o, fp_oe, txd, rx_valid, slip;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 0, done = 0;
  logic [12:0] exp_q [$];
  logic [7:0] tx_model [32];
  logic [7:0] rx_pat [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_stream_port dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every receive strobe (R5)
  always @(negedge clk) begin
    if (mon_en && rx_valid) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected strobe", {19'd0, rx_chan, rx_data}, 0);
      else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        check({rx_chan, rx_data} == e, "R5 strobe chan/data", {19'd0, rx_chan, rx_data}, {19'd0, e});
      end
    end
  end

  task automatic write_tx(input int c, input logic [7:0] d);
    tx_model[c] = d;
    tx_wr_valid = 1; tx_wr_chan = 5'(c); tx_wr_data = d;
    @(negedge clk);
    tx_wr_valid = 0;
  endtask

  // one channel: 8 cells, MSB first; optional frame pulse in bit 0's second period
  task automatic do_chan(input int c, input logic [7:0] d, input bit fp_last,
                         input bit push, output logic [7:0] tb);
    if (push) exp_q.push_back({5'(c), d});
    for (int b = 7; b >= 0; b--) begin
      fp_n_i = 1; bclk_i = 0; rxd = d[b];
      repeat (HQ) @(negedge clk);
      bclk_i = 1;
      repeat (HQ) @(negedge clk);
      bclk_i = 0;
      if (fp_last && b == 0) fp_n_i = 0;
      repeat (HQ) @(negedge clk);
      tb[b] = txd;
      bclk_i = 1;
      repeat (HQ) @(negedge clk);
    end
    fp_n_i = 1;
  endtask

  task automatic do_frame(input int nch, input bit fp_at_end, input string req);
    for (int c = 0; c < nch; c++) begin
      logic [7:0] t;
      do_chan(c, rx_pat[c], fp_at_end && c == nch - 1, 1, t);
      check(t == tx_model[c], req, {24'd0, t}, {24'd0, tx_model[c]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(txd === 1'b1, "R1 reset txd", {31'd0, txd}, 1);
    check(rx_valid === 1'b0, "R1 reset rx_valid", {31'd0, rx_valid}, 0);
    check(slip === 1'b0, "R1 reset slip", {31'd0, slip}, 0);
    check(bclk_oe === 1'b0 && fp_oe === 1'b0, "R11 slave enables", {30'd0, bclk_oe, fp_oe}, 0);
    mon_en = 1;

    for (int c = 0; c < 32; c++) write_tx(c, 8'(8'hA5 ^ (c * 8'd13)));

    // R1: idle channels without a pulse; the last one carries the first pulse
    for (int c = 0; c < 3; c++) begin
      logic [7:0] t;
      do_chan(c, 8'h3C + 8'(c), c == 2, 0, t);
      check(t == 8'hFF, "R1 idle txd before lock", {24'd0, t}, 32'hFF);
    end
    check(slip === 1'b0, "R9 first pulse no slip", {31'd0, slip}, 0);

    // R2 R3 R4 R7 R8: full aligned frame
    for (int c = 0; c < 32; c++) rx_pat[c] = 8'(c * 8'h1D) ^ 8'h5A;
    do_frame(32, 1, "R4 R7 tx byte frame A");
    check(slip === 1'b0, "R9 boundary pulse keeps slip low", {31'd0, slip}, 0);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R5 all frame A strobes seen", exp_q.size(), 0);

    // R6: receive store readback
    foreach (rx_pat[c]) if (c == 0 || c == 17 || c == 31) begin
      rd_chan = 5'(c); #1;
      check(rd_data == rx_pat[c], "R6 rx store readback", {24'd0, rd_data}, {24'd0, rx_pat[c]});
    end

    // R7: rewrite one channel between frames; R8: no pulse at end -> wraps
    write_tx(3, 8'h81);
    for (int c = 0; c < 32; c++) rx_pat[c] = ~8'(c * 8'h27);
    do_frame(32, 0, "R7 R8 tx byte frame B");
    do_frame(4, 0, "R8 wrapped frame tx");

    // R9: pulse inside channel 9 (counters were at channel 4 -> realign to pulse)
    // bench restarts counting from 0 at the pulse; channels before are still locked
    for (int c = 0; c < 32; c++) rx_pat[c] = 8'(c) ^ 8'hC3;
    begin
      for (int c = 4; c < 10; c++) begin
        logic [7:0] t;
        do_chan(c, rx_pat[c], c == 9, 1, t);
        check(t == tx_model[c], "R8 tx continuing frame", {24'd0, t}, {24'd0, tx_model[c]});
      end
    end
    repeat (4) @(negedge clk);
    check(slip === 1'b1, "R9 misplaced pulse sets slip", {31'd0, slip}, 1);
    do_frame(32, 1, "R9 R2 tx after realign");
    check(slip === 1'b1, "R10 slip sticky", {31'd0, slip}, 1);
    slip_clr = 1; @(negedge clk); slip_clr = 0; @(negedge clk);
    check(slip === 1'b0, "R10 slip cleared", {31'd0, slip}, 0);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R5 all strobes seen", exp_q.size(), 0);

    // R11: master mode timing
    mon_en = 0;
    master = 1;
    @(negedge clk);
    check(bclk_oe === 1'b1 && fp_oe === 1'b1, "R11 master enables", {30'd0, bclk_oe, fp_oe}, 3);
    begin
      int n;
      while (bclk_o !== 1'b0) @(negedge clk);
      while (bclk_o !== 1'b1) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (bclk_o !== 1'b0);
      do begin @(negedge clk); n++; end while (bclk_o !== 1'b1);
      check(n == 2 * HQ, "R11 bclk period", n, 2 * HQ);
      while (fp_n_o !== 1'b0) @(negedge clk);
      check(bclk_o === 1'b0, "R11 pulse starts at fall", {31'd0, bclk_o}, 0);
      n = 0;
      do begin @(negedge clk); n++; end while (fp_n_o !== 1'b1);
      check(n == 2 * HQ, "R11 pulse width", n, 2 * HQ);
      do begin @(negedge clk); n++; end while (fp_n_o !== 1'b0);
      check(n == 512 * 2 * HQ, "R11 frame spacing", n, 512 * 2 * HQ);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule